// File: doc/BRIEF.md
# Flash Command Interface with Program Suspend

This block is a synthesizable behavioural controller for a parallel NOR flash. A host writes command bytes and program data over a simple write port. A write state machine runs timed word programming on a small internal array, and an active program can be paused part way so that the host can read other locations. A read-mode multiplexer returns either array contents or the status byte. A busy output reports when the program machine is running.

Two protection inputs gate every program attempt. The first is a write-protect level, active low, which locks the two boot blocks. The second is a flag that says the programming supply is above its lockout level; without it, every block is protected. Both inputs are sampled when a program starts. A refused program never starts, and it leaves sticky error flags in the status byte. Program duration and suspend latency are parameters counted in clock cycles.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, the status byte is 0x80, busy_o is 0, reads are in array mode, and every location reads 0xFF.
- R2: Writing 0x40 and then a write carrying the address and data starts a program when the target is not protected. From the edge that takes the data write, busy_o is 1 and status bit 7 is 0 for exactly PROG_CYCLES cycles. After that, the location reads the new data. Reads return the status byte from the 0x40 write onward.
- R3: Command 0xFF selects array reads and 0x70 selects status reads. In status mode, rd_data equals the status byte whatever rd_addr is. Command 0x50 clears status bits 4, 3 and 1 when no program is active.
- R4: Command 0xB0 during a running program sets status bits 7 and 2 exactly SUSP_LAT cycles after the edge that takes it, provided the program has not finished first. At that point busy_o goes to 0 and reads return the status byte (0x84).
- R5: If the program finishes before the suspend latency expires, it completes normally: the data is written, status becomes 0x80, and bit 2 never sets.
- R6: While suspended, only 0xFF, 0x70 and 0xD0 have any effect. Every other write changes neither the read mode, the status byte nor the array. Array reads return the stored data, and the suspended target still reads its old contents.
- R7: Command 0xD0 while suspended clears status bits 7 and 2 on the next edge, drives busy_o to 1 and selects status reads. The program then finishes after the cycles it had left, so its total running time is PROG_CYCLES.
- R8: With vpp_ok at 0, a program attempt does not start. It sets status bits 4 and 3, leaves busy_o at 0 and leaves the array unchanged.
- R9: With wp_n at 0, a program to one of the two boot blocks fails and sets status bits 4 and 1. The boot blocks are the lowest two blocks when BOOT_TOP is 0 and the highest two otherwise; a block is the top log2(NUM_BLK) address bits. With wp_n at 1, or for a block that is not a boot block, the program proceeds.
- R10: Error bits stay set until an accepted 0x50. While a program is running, only 0xB0 and 0x70 have any effect; for example, 0xFF leaves reads in status mode.
- R11: wp_n and vpp_ok are sampled at the start of a program. A later change during the run does not affect that program, and the inputs must stay stable while the program is suspended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address; it is used only by the program data write |
| wr_data | input | DATA_W | Command byte, or data for the program data write |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Array data or status byte, depending on the read mode |
| sr_o | output | 8 | Status byte: 7 ready, 4 program error, 3 supply error, 2 program suspended, 1 block locked |
| busy_o | output | 1 | 1 while the program machine runs (pin pulled low); 0 means released (high impedance) |
| wp_n | input | 1 | Boot-block write protect, active low |
| vpp_ok | input | 1 | Programming supply above its lockout level |

## Verification
On every cycle, the assertions check these rules:
- a suspended status always shows ready with busy released;
- a resume immediately restores busy and clears the suspend flag;
- a refused program raises the error flag without ever going busy;
- error flags never drop without a clear;
- the suspend flag only follows a pending request;
- the protection inputs stay stable while suspended.

Only the bench scenarios can show the following:
- the exact cycle counts of program length, suspend latency and remaining time after resume;
- that array contents match the commanded data;
- that ignored commands during suspend leave mode, status and array untouched;
- that protection is sampled at start rather than followed during the run.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam logic [7:0] CMD_PROG       = 8'h40;
  localparam logic [7:0] CMD_SUSPEND    = 8'hB0;
  localparam logic [7:0] CMD_RESUME     = 8'hD0;
  localparam logic [7:0] CMD_RD_ARRAY   = 8'hFF;
  localparam logic [7:0] CMD_RD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_CLR_STATUS = 8'h50;

  typedef enum logic [1:0] {
    WSM_IDLE = 2'd0,
    WSM_RUN  = 2'd1,
    WSM_SUSP = 2'd2
  } wsm_state_e;

endpackage

// File: rtl/fcc_protect.sv
module fcc_protect #(
  parameter int NUM_BLK  = 8,
  parameter int BOOT_TOP = 0,
  localparam int BLK_W   = $clog2(NUM_BLK)
) (
  input  logic [BLK_W-1:0] blk_idx,
  input  logic             wp_n,
  input  logic             vpp_ok,
  output logic             lock_hit,
  output logic             vpp_low
);

  logic [NUM_BLK-1:0] boot_mask;

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
    if (BOOT_TOP != 0) begin : g_top
      assign boot_mask[b] = (b >= NUM_BLK - 2);
    end else begin : g_bot
      assign boot_mask[b] = (b < 2);
    end
  end

  assign lock_hit = boot_mask[blk_idx] & ~wp_n;
  assign vpp_low  = ~vpp_ok;

endmodule

// File: rtl/fcc_wsm.sv
module fcc_wsm
  import flash_cmd_pkg::*;
#(
  parameter int PROG_CYCLES = 20,
  parameter int SUSP_LAT    = 4,
  localparam int CNT_W      = $clog2(PROG_CYCLES + 1),
  localparam int LAT_W      = $clog2(SUSP_LAT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic susp_req_i,
  input  logic resume_i,
  output logic run_o,
  output logic susp_o,
  output logic done_o
);

  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PROG_CYCLES);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [LAT_W-1:0] LAT_LOAD = LAT_W'(SUSP_LAT);
  localparam logic [LAT_W-1:0] LAT_ONE  = LAT_W'(1);

  wsm_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [LAT_W-1:0] lat_q, lat_d;
  logic             pend_q, pend_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    lat_d  = lat_q;
    pend_d = pend_q;
    done_o = 1'b0;
    case (st_q)
      WSM_IDLE: begin
        if (start_i) begin
          st_d   = WSM_RUN;
          cnt_d  = CNT_LOAD;
          pend_d = 1'b0;
        end
      end
      WSM_RUN: begin
        cnt_d = cnt_q - 1'b1;
        if (pend_q) begin
          lat_d = lat_q - 1'b1;
        end else if (susp_req_i) begin
          pend_d = 1'b1;
          lat_d  = LAT_LOAD;
        end
        if (cnt_q == CNT_ONE) begin
          done_o = 1'b1;
          st_d   = WSM_IDLE;
          pend_d = 1'b0;
        end else if (pend_q && lat_q == LAT_ONE) begin
          st_d   = WSM_SUSP;
          pend_d = 1'b0;
        end
      end
      WSM_SUSP: begin
        if (resume_i) begin
          st_d = WSM_RUN;
        end
      end
      default: st_d = WSM_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WSM_IDLE;
      cnt_q  <= '0;
      lat_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      lat_q  <= lat_d;
      pend_q <= pend_d;
    end
  end

  assign run_o  = (st_q == WSM_RUN);
  assign susp_o = (st_q == WSM_SUSP);

  AST_SUSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(susp_o) |-> $past(pend_q)); // R4

endmodule

// File: rtl/fcc_array.sv
module fcc_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] cell_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        cell_q[i] <= '1;
      end
    end else if (we) begin
      cell_q[waddr] <= wdata;
    end
  end

  assign rdata = cell_q[raddr];

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 8,
  parameter int NUM_BLK     = 8,
  parameter int BOOT_TOP    = 0,
  parameter int PROG_CYCLES = 20,
  parameter int SUSP_LAT    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [7:0]        sr_o,
  output logic              busy_o,
  input  logic              wp_n,
  input  logic              vpp_ok
);

  localparam int BLK_W = $clog2(NUM_BLK);

  logic [1:0] rst_sync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  logic              run, susp, done;
  logic              lock_hit, vpp_low;
  logic [DATA_W-1:0] arr_rdata;
  logic [7:0]        cmd;

  logic              setup_q, setup_d;
  logic              stat_mode_q, stat_mode_d;
  logic              err_prog_q, err_prog_d;
  logic              err_vpp_q, err_vpp_d;
  logic              err_lock_q, err_lock_d;
  logic [ADDR_W-1:0] tgt_addr_q;
  logic [DATA_W-1:0] tgt_data_q;

  logic idle, cmd_wr, prog_wr, deny, start, fail;
  logic acc_arr, acc_stat, acc_clr, acc_setup, susp_req, resume_req;

  assign cmd = wr_data[7:0];

  fcc_protect #(.NUM_BLK(NUM_BLK), .BOOT_TOP(BOOT_TOP)) u_protect (
    .blk_idx  (wr_addr[ADDR_W-1 -: BLK_W]),
    .wp_n     (wp_n),
    .vpp_ok   (vpp_ok),
    .lock_hit (lock_hit),
    .vpp_low  (vpp_low)
  );

  fcc_wsm #(.PROG_CYCLES(PROG_CYCLES), .SUSP_LAT(SUSP_LAT)) u_wsm (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .start_i    (start),
    .susp_req_i (susp_req),
    .resume_i   (resume_req),
    .run_o      (run),
    .susp_o     (susp),
    .done_o     (done)
  );

  fcc_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk   (clk),
    .rst_n (rst_s_n),
    .we    (done),
    .waddr (tgt_addr_q),
    .wdata (tgt_data_q),
    .raddr (rd_addr),
    .rdata (arr_rdata)
  );

  // Command decode and next state
  always_comb begin
    idle       = !run && !susp;
    cmd_wr     = wr_en && !setup_q;
    prog_wr    = wr_en && setup_q;
    deny       = lock_hit || vpp_low;
    start      = prog_wr && !deny;
    fail       = prog_wr && deny;
    acc_arr    = cmd_wr && (cmd == CMD_RD_ARRAY) && !run;
    acc_stat   = cmd_wr && (cmd == CMD_RD_STATUS);
    acc_clr    = cmd_wr && (cmd == CMD_CLR_STATUS) && idle;
    acc_setup  = cmd_wr && (cmd == CMD_PROG) && idle;
    susp_req   = cmd_wr && (cmd == CMD_SUSPEND) && run;
    resume_req = cmd_wr && (cmd == CMD_RESUME) && susp;

    setup_d = setup_q;
    if (acc_setup)    setup_d = 1'b1;
    else if (prog_wr) setup_d = 1'b0;

    stat_mode_d = stat_mode_q;
    if (acc_stat || acc_setup || susp_req || resume_req) stat_mode_d = 1'b1;
    else if (acc_arr)                                     stat_mode_d = 1'b0;

    err_prog_d = err_prog_q;
    err_vpp_d  = err_vpp_q;
    err_lock_d = err_lock_q;
    if (acc_clr) begin
      err_prog_d = 1'b0;
      err_vpp_d  = 1'b0;
      err_lock_d = 1'b0;
    end else if (fail) begin
      err_prog_d = 1'b1;
      err_vpp_d  = err_vpp_q | vpp_low;
      err_lock_d = err_lock_q | lock_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      setup_q     <= 1'b0;
      stat_mode_q <= 1'b0;
      err_prog_q  <= 1'b0;
      err_vpp_q   <= 1'b0;
      err_lock_q  <= 1'b0;
    end else begin
      setup_q     <= setup_d;
      stat_mode_q <= stat_mode_d;
      err_prog_q  <= err_prog_d;
      err_vpp_q   <= err_vpp_d;
      err_lock_q  <= err_lock_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      tgt_addr_q <= '0;
      tgt_data_q <= '0;
    end else if (start) begin
      tgt_addr_q <= wr_addr;
      tgt_data_q <= wr_data;
    end
  end

  assign sr_o    = {!run, 2'b00, err_prog_q, err_vpp_q, susp, err_lock_q, 1'b0};
  assign busy_o  = run;
  assign rd_data = stat_mode_q ? DATA_W'(sr_o) : arr_rdata;

  AST_SUSP_FLAGS: assert property (@(posedge clk) disable iff (!rst_s_n)
    sr_o[2] |-> (sr_o[7] && !busy_o)); // R4
  AST_RESUME_BUSY: assert property (@(posedge clk) disable iff (!rst_s_n)
    resume_req |=> (busy_o && !sr_o[2] && !sr_o[7])); // R7
  AST_DENY_NO_RUN: assert property (@(posedge clk) disable iff (!rst_s_n)
    fail |=> (sr_o[4] && !busy_o)); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_s_n)
    (sr_o[4] && !acc_clr) |=> sr_o[4]); // R10
  AST_PROT_STABLE: assert property (@(posedge clk) disable iff (!rst_s_n)
    sr_o[2] |-> ($stable(wp_n) && $stable(vpp_ok))); // R11

endmodule

// File: tb/tb_flash_cmd_ctrl.sv
module tb_flash_cmd_ctrl;

  localparam int AW = 6;
  localparam int DW = 8;
  localparam int P  = 20;
  localparam int L  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic [7:0]    sr_o;
  logic          busy_o;
  logic          wp_n = 1'b1;
  logic          vpp_ok = 1'b1;

  int nchk = 0;
  int nerr = 0;
  logic [7:0] bmem [1 << AW];

  flash_cmd_ctrl #(.ADDR_W(AW), .DATA_W(DW), .NUM_BLK(8), .BOOT_TOP(0),
                   .PROG_CYCLES(P), .SUSP_LAT(L)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .sr_o(sr_o),
    .busy_o(busy_o), .wp_n(wp_n), .vpp_ok(vpp_ok)
  );

  always #10 clk = ~clk;

  function automatic logic [7:0] fail_sr(input logic [AW-1:0] a, input logic w, input logic v);
    logic [7:0] s;
    s = 8'h80;
    if (!v) s = s | 8'h18;
    if (!w && (a >> 3) < 2) s = s | 8'h12;
    return s;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [AW-1:0] a, input logic [7:0] exp);
    rd_addr = a;
    #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic wait_ready();
    int guard = 0;
    while (busy_o && guard < 500) begin
      step(1);
      guard++;
    end
  endtask

  initial begin
    #(20 * 200000);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [AW-1:0] a, b;
    logic [7:0] d;
    logic w, v;
    int k;
    void'($urandom(32'd4242));
    for (int i = 0; i < (1 << AW); i++) bmem[i] = 8'hFF;
    step(3);
    rst_n = 1'b1;
    step(4);

    // R1 reset state
    chk("R1 status", sr_o, 8'h80);
    chk("R1 busy", {7'd0, busy_o}, 8'h00);
    rd_chk("R1 erased", 6'd5, 8'hFF);

    // R2 program timing
    wr(0, 8'h40);
    rd_chk("R2 status after setup", 6'd9, 8'h80);
    wr(6'd20, 8'h5A);
    chk("R2 busy k0", {7'd0, busy_o}, 8'h01);
    for (int i = 1; i < P; i++) begin
      step(1);
      chk("R2 busy during program", {busy_o, sr_o[7]}, 8'h02);
    end
    step(1);
    chk("R2 ready at end", sr_o, 8'h80);
    bmem[20] = 8'h5A;
    wr(0, 8'hFF);
    rd_chk("R2 data written", 6'd20, 8'h5A);
    wr(0, 8'h70);
    rd_chk("R3 status mode any addr", 6'd33, 8'h80);
    wr(0, 8'hFF);
    rd_chk("R3 array mode", 6'd21, 8'hFF);

    // R10 ignored commands during a program
    wr(0, 8'h40);
    wr(6'd21, 8'h33);
    wr(0, 8'hFF);
    rd_chk("R10 FF ignored while running", 6'd21, 8'h00);
    wait_ready();
    bmem[21] = 8'h33;
    wr(0, 8'hFF);
    rd_chk("R2 second program", 6'd21, 8'h33);

    // R4/R6/R7 suspend, restricted commands, resume
    wr(0, 8'h40);
    wr(6'd30, 8'hC3);
    step(3);
    wr(0, 8'hB0);
    step(L - 1);
    chk("R4 not yet suspended", sr_o, 8'h00);
    step(1);
    chk("R4 suspended status", sr_o, 8'h84);
    chk("R4 busy released", {7'd0, busy_o}, 8'h00);
    rd_chk("R4 reads status", 6'd2, 8'h84);
    wr(0, 8'h40);
    wr(6'd31, 8'h11);
    wr(0, 8'h50);
    chk("R6 ignored keeps status", sr_o, 8'h84);
    rd_chk("R6 ignored keeps status mode", 6'd31, 8'h84);
    wr(0, 8'hFF);
    rd_chk("R6 suspended target old data", 6'd30, 8'hFF);
    rd_chk("R6 other location", 6'd20, 8'h5A);
    rd_chk("R6 ignored write left array", 6'd31, 8'hFF);
    wr(0, 8'h40);
    rd_chk("R6 ignored keeps array mode", 6'd20, 8'h5A);
    wr(0, 8'hD0);
    chk("R7 resume clears", sr_o, 8'h00);
    chk("R7 busy again", {7'd0, busy_o}, 8'h01);
    rd_chk("R7 status mode", 6'd20, 8'h00);
    step(P - (3 + 1 + L) - 1);
    chk("R7 still busy before remaining", {7'd0, busy_o}, 8'h01);
    step(1);
    chk("R7 done after remaining", sr_o, 8'h80);
    bmem[30] = 8'hC3;
    wr(0, 8'hFF);
    rd_chk("R7 target written", 6'd30, 8'hC3);
    rd_chk("R6 neighbour untouched", 6'd31, 8'hFF);

    // R5 suspend that arrives too late
    wr(0, 8'h40);
    wr(6'd40, 8'h77);
    step(P - 3);
    wr(0, 8'hB0);
    step(1);
    chk("R5 still running", {7'd0, busy_o}, 8'h01);
    step(1);
    chk("R5 completes normally", sr_o, 8'h80);
    step(L);
    chk("R5 no suspend flag", sr_o, 8'h80);
    bmem[40] = 8'h77;
    wr(0, 8'hFF);
    rd_chk("R5 data", 6'd40, 8'h77);

    // R8 supply below lockout
    vpp_ok = 1'b0;
    wr(0, 8'h40);
    wr(6'd50, 8'h12);
    chk("R8 vpp fail status", sr_o, 8'h98);
    step(1);
    chk("R8 never busy", {7'd0, busy_o}, 8'h00);
    vpp_ok = 1'b1;
    wr(0, 8'h70);
    chk("R10 error sticky", sr_o, 8'h98);
    wr(0, 8'hFF);
    rd_chk("R8 array unchanged", 6'd50, 8'hFF);
    wr(0, 8'h50);
    chk("R3 clear status", sr_o, 8'h80);

    // R9 boot block lock
    wp_n = 1'b0;
    wr(0, 8'h40);
    wr(6'd3, 8'hA1);
    chk("R9 boot block 0 locked", sr_o, 8'h92);
    wr(0, 8'h50);
    wr(0, 8'h40);
    wr(6'd12, 8'hA2);
    chk("R9 boot block 1 locked", sr_o, 8'h92);
    wr(0, 8'h50);
    wr(0, 8'h40);
    wr(6'd16, 8'hA3);
    wait_ready();
    chk("R9 non-boot ok", sr_o, 8'h80);
    bmem[16] = 8'hA3;
    vpp_ok = 1'b0;
    wr(0, 8'h40);
    wr(6'd5, 8'hA4);
    chk("R9 R8 both errors", sr_o, 8'h9A);
    vpp_ok = 1'b1;
    wr(0, 8'h50);
    wp_n = 1'b1;

    // R11 sampled at start
    wr(0, 8'h40);
    wr(6'd3, 8'hB7);
    step(2);
    wp_n = 1'b0;
    wait_ready();
    chk("R11 sampled protection", sr_o, 8'h80);
    bmem[3] = 8'hB7;
    wp_n = 1'b1;
    wr(0, 8'hFF);
    rd_chk("R11 data in boot block", 6'd3, 8'hB7);
    rd_chk("R9 locked attempts left array", 6'd12, 8'hFF);

    // Random programs with optional suspend
    for (int it = 0; it < 40; it++) begin
      a = AW'($urandom % (1 << AW));
      d = 8'($urandom);
      w = 1'($urandom % 2);
      v = (($urandom % 4) != 0);
      wp_n = w; vpp_ok = v;
      wr(0, 8'h50);
      wr(0, 8'h40);
      wr(a, d);
      if (fail_sr(a, w, v) != 8'h80) begin
        chk("R8 R9 random refusal", sr_o, fail_sr(a, w, v));
      end else begin
        if (($urandom % 2) == 1) begin
          k = int'($urandom % (P - L - 1));
          step(k);
          wr(0, 8'hB0);
          step(L);
          chk("R4 random suspend", sr_o, 8'h84);
          wr(0, 8'hFF);
          b = AW'($urandom % (1 << AW));
          if (b == a) b = a ^ 6'd1;
          rd_chk("R6 random read in suspend", b, bmem[b]);
          rd_chk("R6 random target old", a, bmem[a]);
          wr(0, 8'hD0);
        end
        wait_ready();
        chk("R2 random done", sr_o, 8'h80);
        bmem[a] = d;
      end
      wr(0, 8'hFF);
      rd_chk("R2 random array", a, bmem[a]);
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule